// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block closes out one bus transaction for a host controller's transfer engine. It takes the descriptor's control word, its token word and the outcome the transaction issuer reported, and returns three things: the control word to write back, a two-bit interrupt cause mask and a result code. The result code tells the list walker what to do next: advance the queue, skip to the next entry, wait on a pending transfer, or abort the frame. The same cycle also splits the token into packet identifier, device address, endpoint number and maximum transfer length, so the issuer can build the packet.

Results are registered once, so they appear one clock after a word is presented with `in_valid` high. A new descriptor can be accepted on every clock. Memory reads and writes and the data movement belong to the surrounding engine.

Outcome codes on `in_outcome`: 0 done (with a byte count), 1 NAK, 2 stall, 3 no device, 4 babble, 5 pending. Codes 6 and 7 are treated like no device. Result codes on `out_result`: 0 success, 1 skip, 2 pending, 3 frame abort. The packet identifiers recognised are SETUP 0x2D, IN 0x69 and OUT 0xE1.

Top module: `td_status_update`

## Requirements
- R1: The token is decoded as follows. The packet identifier is bits 7:0, the device address is bits 14:8 and the endpoint is bits 18:15. The maximum length is (bits 31:21 plus one) truncated to 11 bits, so a field of 0x7FF gives 0.
- R2: If control bit 24 (interrupt on complete) is set, cause bit 0 is raised whatever else happens. A word whose bit 23 (active) is clear returns skip (1) and comes back unchanged.
- R3: For a done outcome, the length used is the maximum length for OUT and SETUP, and the returned count for IN. Bits 10:0 receive (length − 1) mod 2048, bit 23 is cleared, and the result is success (0).
- R4: For an IN whose count exceeds the maximum length, the babble path is taken. The same path is taken for a babble outcome. On this path bits 20 and 22 are set, bit 23 is cleared, bits 10:0 are left alone and the result is frame abort (3).
- R5: For an IN done outcome with bit 29 (short packet detect) set and a length below the maximum, cause bit 1 is raised and the result is skip rather than success.
- R6: On a no-device outcome (or code 6 or 7), bit 18 (timeout) is set. The two-bit counter in bits 28:27 is then handled: if it is nonzero it is decremented, and if it reaches zero bit 23 is cleared and `out_usb_err` is raised. A counter of zero stays zero and raises no error. The result is skip.
- R7: A NAK sets bit 19 and returns skip. For a SETUP packet, a NAK additionally takes the whole timeout path of R6.
- R8: A stall sets bit 22, clears bit 23 and returns skip.
- R9: An active word whose packet identifier is none of SETUP, IN and OUT raises `out_proc_err`, returns frame abort and leaves the control word unchanged.
- R10: If bit 25 (isochronous) is set, bit 23 is cleared on every outcome that is not pending for an active word with a valid identifier.
- R11: A pending outcome on an active word with a valid identifier returns pending (2) and leaves the control word unchanged.
- R12: After reset, `out_valid` and all outputs are zero. `out_valid` follows `in_valid` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor words presented this cycle |
| in_ctrl | input | 32 | Descriptor control word |
| in_token | input | 32 | Descriptor token word |
| in_outcome | input | 3 | Transaction outcome code |
| in_count | input | CNT_W (16) | Byte count returned by the device for IN |
| out_valid | output | 1 | Results below belong to last cycle's input |
| out_ctrl | output | 32 | Updated control word |
| out_cause | output | 2 | Interrupt causes: bit 0 complete, bit 1 short packet |
| out_result | output | 2 | Result code |
| out_usb_err | output | 1 | Retry counter exhausted |
| out_proc_err | output | 1 | Unknown packet identifier |
| out_pid | output | 8 | Decoded packet identifier |
| out_dev_addr | output | 7 | Decoded device address |
| out_endp | output | 4 | Decoded endpoint |
| out_max_len | output | 11 | Decoded maximum length |

## Verification
Several functions can fall on the same descriptor in one cycle, and the bench builds words that make them coincide.

- **Completion interrupt with short packet.** A short IN with both the completion interrupt and short-packet detect set must report cause 2'b11 together with skip.
- **Isochronous clear with NAK.** An isochronous word that receives a NAK must both clear active and set the NAK bit.
- **Timeout path with counter expiry.** A SETUP NAK with a counter of one must set the NAK and timeout bits, clear active and flag the error, all in the same returned word.

Each of these is judged against a behavioural reference model evaluated for the same inputs.

// File: rtl/td_pkg.sv
package td_pkg;
    localparam int LEN_W   = 11;
    localparam int WORD_W  = 32;

    // control word bit positions (consumed by the list walker)
    localparam int B_SPD    = 29;
    localparam int B_ERR_HI = 28;
    localparam int B_ERR_LO = 27;
    localparam int B_ISO    = 25;
    localparam int B_IOC    = 24;
    localparam int B_ACT    = 23;
    localparam int B_STALL  = 22;
    localparam int B_BABBLE = 20;
    localparam int B_NAK    = 19;
    localparam int B_TMO    = 18;

    localparam logic [7:0] PID_SETUP = 8'h2D;
    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_OUT   = 8'hE1;

    localparam logic [2:0] OC_DONE   = 3'd0;
    localparam logic [2:0] OC_NAK    = 3'd1;
    localparam logic [2:0] OC_STALL  = 3'd2;
    localparam logic [2:0] OC_NODEV  = 3'd3;
    localparam logic [2:0] OC_BABBLE = 3'd4;
    localparam logic [2:0] OC_PEND   = 3'd5;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_SKIP  = 2'd1,
        RES_PEND  = 2'd2,
        RES_ABORT = 2'd3
    } result_e;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
    import td_pkg::*;
(
    input  logic [WORD_W-1:0] token,
    output logic [7:0]        pid,
    output logic [6:0]        dev_addr,
    output logic [3:0]        endp,
    output logic [LEN_W-1:0]  max_len
);
    logic unused_tok_bits;

    assign pid             = token[7:0];
    assign dev_addr        = token[14:8];
    assign endp            = token[18:15];
    assign max_len         = token[31:21] + LEN_W'(1);
    assign unused_tok_bits = ^token[20:19];
endmodule

// File: rtl/td_outcome_eval.sv
module td_outcome_eval
    import td_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [WORD_W-1:0] ctrl,
    input  logic [7:0]        pid,
    input  logic [LEN_W-1:0]  max_len,
    input  logic [2:0]        outcome,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] ctrl_new,
    output logic [1:0]        cause,
    output result_e           result,
    output logic              usb_err,
    output logic              proc_err
);
    logic             is_in, is_setup, pid_ok, overrun, do_tmo;
    logic [LEN_W-1:0] xfer_len;
    logic [1:0]       err_cnt;

    assign is_in    = (pid == PID_IN);
    assign is_setup = (pid == PID_SETUP);
    assign pid_ok   = is_in || is_setup || (pid == PID_OUT);
    assign overrun  = is_in && (outcome == OC_DONE) && (count > CNT_W'(max_len));

    always_comb begin
        if (!is_in)       xfer_len = max_len;
        else if (overrun) xfer_len = max_len;
        else              xfer_len = count[LEN_W-1:0];
    end

    always_comb begin
        ctrl_new = ctrl;
        cause    = {1'b0, ctrl[B_IOC]};
        result   = RES_SKIP;
        usb_err  = 1'b0;
        proc_err = 1'b0;
        do_tmo   = 1'b0;
        err_cnt  = ctrl[B_ERR_HI:B_ERR_LO];
        if (!ctrl[B_ACT]) begin
            result = RES_SKIP;
        end else if (!pid_ok) begin
            proc_err = 1'b1;
            result   = RES_ABORT;
        end else if (outcome == OC_PEND) begin
            result = RES_PEND;
        end else begin
            if (ctrl[B_ISO]) ctrl_new[B_ACT] = 1'b0;
            if (outcome == OC_BABBLE || overrun) begin
                ctrl_new[B_BABBLE] = 1'b1;
                ctrl_new[B_STALL]  = 1'b1;
                ctrl_new[B_ACT]    = 1'b0;
                result             = RES_ABORT;
            end else if (outcome == OC_DONE) begin
                ctrl_new[LEN_W-1:0] = xfer_len - LEN_W'(1);
                ctrl_new[B_ACT]     = 1'b0;
                if (is_in && ctrl[B_SPD] && (xfer_len < max_len)) begin
                    cause[1] = 1'b1;
                    result   = RES_SKIP;
                end else begin
                    result = RES_OK;
                end
            end else if (outcome == OC_STALL) begin
                ctrl_new[B_STALL] = 1'b1;
                ctrl_new[B_ACT]   = 1'b0;
            end else if (outcome == OC_NAK) begin
                ctrl_new[B_NAK] = 1'b1;
                do_tmo          = is_setup;
            end else begin
                do_tmo = 1'b1;
            end
            if (do_tmo) begin
                ctrl_new[B_TMO] = 1'b1;
                if (err_cnt != 2'd0) begin
                    err_cnt = err_cnt - 2'd1;
                    if (err_cnt == 2'd0) begin
                        ctrl_new[B_ACT] = 1'b0;
                        usb_err         = 1'b1;
                    end
                end
                ctrl_new[B_ERR_HI:B_ERR_LO] = err_cnt;
            end
        end
    end
endmodule

// File: rtl/td_status_update.sv
module td_status_update
    import td_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_ctrl,
    input  logic [WORD_W-1:0]   in_token,
    input  logic [2:0]          in_outcome,
    input  logic [CNT_W-1:0]    in_count,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_ctrl,
    output logic [1:0]          out_cause,
    output logic [1:0]          out_result,
    output logic                out_usb_err,
    output logic                out_proc_err,
    output logic [7:0]          out_pid,
    output logic [6:0]          out_dev_addr,
    output logic [3:0]          out_endp,
    output logic [LEN_W-1:0]    out_max_len
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] ctrl;
        logic [1:0]        cause;
        result_e           result;
        logic              usb_err;
        logic              proc_err;
        logic [7:0]        pid;
        logic [6:0]        dev_addr;
        logic [3:0]        endp;
        logic [LEN_W-1:0]  max_len;
    } state_t;

    state_t st_d, st_q;

    logic [7:0]        dec_pid;
    logic [6:0]        dec_addr;
    logic [3:0]        dec_endp;
    logic [LEN_W-1:0]  dec_max;
    logic [WORD_W-1:0] ev_ctrl;
    logic [1:0]        ev_cause;
    result_e           ev_result;
    logic              ev_usb_err, ev_proc_err;

    td_token_decode u_dec (
        .token    (in_token),
        .pid      (dec_pid),
        .dev_addr (dec_addr),
        .endp     (dec_endp),
        .max_len  (dec_max)
    );

    td_outcome_eval #(.CNT_W(CNT_W)) u_eval (
        .ctrl     (in_ctrl),
        .pid      (dec_pid),
        .max_len  (dec_max),
        .outcome  (in_outcome),
        .count    (in_count),
        .ctrl_new (ev_ctrl),
        .cause    (ev_cause),
        .result   (ev_result),
        .usb_err  (ev_usb_err),
        .proc_err (ev_proc_err)
    );

    always_comb begin
        st_d          = st_q;
        st_d.valid    = in_valid;
        if (in_valid) begin
            st_d.ctrl     = ev_ctrl;
            st_d.cause    = ev_cause;
            st_d.result   = ev_result;
            st_d.usb_err  = ev_usb_err;
            st_d.proc_err = ev_proc_err;
            st_d.pid      = dec_pid;
            st_d.dev_addr = dec_addr;
            st_d.endp     = dec_endp;
            st_d.max_len  = dec_max;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign out_ctrl     = st_q.ctrl;
    assign out_cause    = st_q.cause;
    assign out_result   = st_q.result;
    assign out_usb_err  = st_q.usb_err;
    assign out_proc_err = st_q.proc_err;
    assign out_pid      = st_q.pid;
    assign out_dev_addr = st_q.dev_addr;
    assign out_endp     = st_q.endp;
    assign out_max_len  = st_q.max_len;

    // R12
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R11
    pend_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result == RES_PEND) |-> out_ctrl == $past(in_ctrl));

    // R9
    bad_pid_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_proc_err) |->
            (out_result == RES_ABORT && out_ctrl == $past(in_ctrl)));

    // R6
    retry_exhaust_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_usb_err) |->
            (!out_ctrl[B_ACT] && out_ctrl[B_TMO] && out_ctrl[B_ERR_HI:B_ERR_LO] == 2'd0));

    // R5
    short_pkt_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cause[1]) |-> (out_result == RES_SKIP && !out_ctrl[B_ACT]));

    // R3
    success_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result == RES_OK) |-> !out_ctrl[B_ACT]);

    // R2
    idle_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_ctrl[B_ACT])) |->
            (out_result == RES_SKIP && out_ctrl == $past(in_ctrl)));

    // R4
    babble_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl[B_BABBLE] && !$past(in_ctrl[B_BABBLE])) |->
            (out_result == RES_ABORT && out_ctrl[B_STALL] && !out_ctrl[B_ACT]));
endmodule

// File: tb/tb_td_status_update.sv
`timescale 1ns/1ps
module tb_td_status_update;
    localparam int CNT_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [31:0]       in_ctrl, in_token;
    logic [2:0]        in_outcome;
    logic [CNT_W-1:0]  in_count;
    logic              out_valid;
    logic [31:0]       out_ctrl;
    logic [1:0]        out_cause, out_result;
    logic              out_usb_err, out_proc_err;
    logic [7:0]        out_pid;
    logic [6:0]        out_dev_addr;
    logic [3:0]        out_endp;
    logic [10:0]       out_max_len;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    always #2 clk = ~clk;

    td_status_update #(.CNT_W(CNT_W)) dut (.*);

    // expected values for the word presented last cycle
    logic        e_valid;
    logic [31:0] e_ctrl;
    logic [1:0]  e_cause, e_res;
    logic        e_ue, e_pe;
    logic [7:0]  e_pid;
    logic [6:0]  e_addr;
    logic [3:0]  e_endp;
    logic [10:0] e_max;
    string       e_tag;

    function automatic logic [31:0] mk_tok(int pid, int addr, int ep, int mlm1);
        return (32'(mlm1) << 21) | (32'(ep) << 15) | (32'(addr) << 8) | 32'(pid);
    endfunction

    function automatic void ref_model(input logic [31:0] ctl, input logic [31:0] tok,
                                      input int oc, input int cnt,
                                      output logic [31:0] nctl, output logic [1:0] cause,
                                      output logic [1:0] res, output logic ue, output logic pe);
        int  maxl, len, pid, err;
        bit  in_pkt, bab;
        nctl = ctl; cause = 2'b00; res = 2'd1; ue = 0; pe = 0;
        maxl = (int'(tok >> 21) + 1) % 2048;
        pid  = int'(tok & 32'hFF);
        if (ctl[24]) cause[0] = 1'b1;
        if (!ctl[23]) return;
        if (pid != 'h2D && pid != 'h69 && pid != 'hE1) begin
            pe = 1; res = 2'd3; return;
        end
        if (oc == 5) begin res = 2'd2; return; end
        in_pkt = (pid == 'h69);
        bab    = 0;
        if (in_pkt) begin
            len = cnt;
            if (oc == 0 && cnt > maxl) begin bab = 1; len = maxl; end
        end else len = maxl;
        if (ctl[25]) nctl[23] = 1'b0;
        if (oc == 4 || bab) begin
            nctl[20] = 1; nctl[22] = 1; nctl[23] = 0; res = 2'd3; return;
        end
        if (oc == 0) begin
            nctl[10:0] = 11'((len + 2047) % 2048);
            nctl[23]   = 0;
            if (in_pkt && ctl[29] && len < maxl) begin cause[1] = 1; res = 2'd1; end
            else res = 2'd0;
            return;
        end
        if (oc == 2) begin nctl[22] = 1; nctl[23] = 0; return; end
        if (oc == 1) begin
            nctl[19] = 1;
            if (pid != 'h2D) return;
        end
        nctl[18] = 1;
        err = int'(ctl[28:27]);
        if (err > 0) begin
            err = err - 1;
            if (err == 0) begin nctl[23] = 0; ue = 1; end
        end
        nctl[28:27] = 2'(err);
    endfunction

    task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] exp);
        mismatched++;
        $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    endtask

    task automatic compare_now();
        compared++;
        if (out_valid !== e_valid) begin
            fail(e_tag, "out_valid (R12)", 32'(out_valid), 32'(e_valid));
            return;
        end
        if (!e_valid) return;
        if (out_ctrl     !== e_ctrl)  fail(e_tag, "ctrl",     out_ctrl, e_ctrl);
        if (out_cause    !== e_cause) fail(e_tag, "cause",    32'(out_cause), 32'(e_cause));
        if (out_result   !== e_res)   fail(e_tag, "result",   32'(out_result), 32'(e_res));
        if (out_usb_err  !== e_ue)    fail(e_tag, "usb_err",  32'(out_usb_err), 32'(e_ue));
        if (out_proc_err !== e_pe)    fail(e_tag, "proc_err", 32'(out_proc_err), 32'(e_pe));
        if (out_pid      !== e_pid)   fail(e_tag, "pid",      32'(out_pid), 32'(e_pid));
        if (out_dev_addr !== e_addr)  fail(e_tag, "addr",     32'(out_dev_addr), 32'(e_addr));
        if (out_endp     !== e_endp)  fail(e_tag, "endp",     32'(out_endp), 32'(e_endp));
        if (out_max_len  !== e_max)   fail(e_tag, "max_len",  32'(out_max_len), 32'(e_max));
    endtask

    // called at a negedge: drive, advance one clock, compare at the next negedge
    task automatic apply(logic [31:0] ctl, logic [31:0] tok, int oc, int cnt, string tag);
        in_valid   = 1'b1;
        in_ctrl    = ctl;
        in_token   = tok;
        in_outcome = 3'(oc);
        in_count   = CNT_W'(cnt);
        ref_model(ctl, tok, oc, cnt, e_ctrl, e_cause, e_res, e_ue, e_pe);
        e_valid = 1'b1;
        e_pid   = tok[7:0];
        e_addr  = tok[14:8];
        e_endp  = tok[18:15];
        e_max   = 11'((int'(tok >> 21) + 1) % 2048);
        e_tag   = tag;
        @(negedge clk);
        compare_now();
    endtask

    task automatic idle(string tag);
        in_valid = 1'b0;
        e_valid  = 1'b0;
        e_tag    = tag;
        @(negedge clk);
        compare_now();
    endtask

    localparam logic [31:0] ACT = 32'h0080_0000;
    localparam logic [31:0] IOC = 32'h0100_0000;
    localparam logic [31:0] ISO = 32'h0200_0000;
    localparam logic [31:0] SPD = 32'h2000_0000;

    function automatic logic [31:0] errc(int n);
        return 32'(n) << 27;
    endfunction

    initial begin
        #200000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_ctrl = '0; in_token = '0;
        in_outcome = '0; in_count = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        compared++;
        if (out_valid !== 1'b0 || out_ctrl !== 32'h0 || out_result !== 2'd0)
            fail("R12", "reset outputs", {out_valid, out_ctrl[30:0]}, 32'h0);
        rst_n = 1'b1;
        idle("R12 idle");

        // R1 decode fields
        apply(ACT, mk_tok('h69, 'h55, 'hA, 63), 0, 64, "R1 decode");
        apply(ACT, mk_tok('hE1, 'h7F, 'hF, 'h7FF), 0, 0, "R1 zero max");
        // R2 inactive with completion interrupt
        apply(IOC | 32'h0000_0123, mk_tok('h69, 1, 1, 7), 0, 3, "R2 inactive");
        // R3 done paths
        apply(ACT, mk_tok('hE1, 2, 0, 7), 0, 99, "R3 out done");
        apply(ACT | errc(3), mk_tok('h2D, 2, 0, 7), 0, 0, "R3 setup done");
        apply(ACT, mk_tok('h69, 3, 1, 63), 0, 64, "R3 in full");
        apply(ACT, mk_tok('h69, 3, 1, 63), 0, 0, "R3 in zero");
        // R5 short packet, together with completion interrupt
        apply(ACT | SPD | IOC, mk_tok('h69, 4, 2, 63), 0, 5, "R5 short");
        apply(ACT | SPD, mk_tok('h69, 4, 2, 63), 0, 64, "R5 not short");
        // R4 overrun and babble outcome
        apply(ACT | 32'h0000_0055, mk_tok('h69, 5, 3, 63), 0, 70, "R4 overrun");
        apply(ACT, mk_tok('hE1, 5, 3, 15), 4, 0, "R4 babble");
        // R6 retry counter
        apply(ACT | errc(3), mk_tok('h69, 6, 0, 7), 3, 0, "R6 dec");
        apply(ACT | errc(1), mk_tok('hE1, 6, 0, 7), 3, 0, "R6 expire");
        apply(ACT | errc(0), mk_tok('hE1, 6, 0, 7), 7, 0, "R6 zero");
        // R7 NAK
        apply(ACT | errc(2), mk_tok('h69, 7, 0, 7), 1, 0, "R7 in nak");
        apply(ACT | errc(1), mk_tok('h2D, 7, 0, 7), 1, 0, "R7 setup nak");
        // R8 stall
        apply(ACT, mk_tok('hE1, 8, 0, 7), 2, 0, "R8 stall");
        // R9 bad pid
        apply(ACT | IOC, mk_tok('h55, 9, 0, 7), 0, 3, "R9 bad pid");
        // R10 isochronous
        apply(ACT | ISO | errc(3), mk_tok('h69, 10, 0, 7), 1, 0, "R10 iso nak");
        apply(ACT | ISO, mk_tok('h69, 10, 0, 7), 5, 0, "R10 iso pend");
        // R11 pending
        apply(ACT | IOC | errc(2), mk_tok('h2D, 11, 0, 7), 5, 0, "R11 pend");
        idle("R12 gap");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] c, t;
            int          p, sel;
            sel = int'($urandom % 5);
            case (sel)
                0: p = 'h69;
                1: p = 'hE1;
                2: p = 'h2D;
                3: p = 'h69;
                default: p = int'($urandom % 256);
            endcase
            c = $urandom;
            if ($urandom % 4 != 0) c[23] = 1'b1;
            t = $urandom;
            t[7:0] = 8'(p);
            t[31:21] = 11'($urandom % 80);
            apply(c, t, int'($urandom % 8), int'($urandom % 100), "R1-mix random");
            if (i % 50 == 0) idle("R12 random gap");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule